// File: doc/BRIEF.md
# Stereo Serial Audio Input Receiver

This block takes a three-wire stereo PCM stream (bit clock, frame clock and serial data) and turns it into parallel left and right sample words. All three wires are sampled in the system clock domain. A rising edge of the bit clock is found by comparing its current level with the level held from the previous system cycle. The data bit and the frame-clock level are taken at that same cycle. Samples are two's complement and arrive most significant bit first.

Two framings are accepted. In right-justified framing the sample sits at the end of each half-frame. In I2S framing the sample starts one bit after the frame-clock transition. The sample length is 16 or 18 bits, and the frame-clock polarity can be reversed. A strap input overrides all three configuration inputs and locks the receiver to 16-bit right-justified framing with normal polarity. Each completed stereo pair is presented as two sign-extended 18-bit words together with a one-cycle valid pulse.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted, `pcm_valid_o` is 0 and both `pcm_left_o` and `pcm_right_o` are 0.
- R2: With `fmt_i2s_i`=0 (right-justified), the word of a half-frame is the last N bits sampled on rising bit-clock edges before the edge at which the frame clock is seen at its new level. Any earlier bits in that half-frame are ignored.
- R3: With `fmt_i2s_i`=1 (I2S), the MSB of a word is sampled on the second rising bit-clock edge after a frame-clock transition, and the next N-1 edges carry the rest of the word. Any bits that follow in the same half-frame are ignored.
- R4: N is 16 when `len_long_i`=0 and 18 when it is 1. A 16-bit word is sign-extended from its bit 15 into the 18-bit outputs.
- R5: With `lr_swap_i`=0, a high frame clock marks left-channel data and a low one marks right-channel data. With `lr_swap_i`=1 the meaning of the two levels is swapped.
- R6: `pcm_valid_o` pulses high for exactly one cycle when a right word is captured after a left word. Both output words update only in that cycle and hold their values otherwise. A right word with no preceding left word is dropped.
- R7: With `strap_mode_i`=1, the receiver behaves as right-justified, 16-bit, normal polarity, whatever `fmt_i2s_i`, `len_long_i` and `lr_swap_i` say.
- R8: No word is captured until a frame-clock transition has been seen on a rising bit-clock edge after reset. A frame clock held at one level produces no valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk_i | input | 1 | Serial bit clock, sampled by clk |
| frame_clk_i | input | 1 | Left/right frame clock |
| ser_data_i | input | 1 | Serial audio data, MSB first |
| fmt_i2s_i | input | 1 | 1 = I2S framing, 0 = right-justified |
| len_long_i | input | 1 | 1 = 18-bit words, 0 = 16-bit words |
| lr_swap_i | input | 1 | 1 = reverse the frame-clock polarity |
| strap_mode_i | input | 1 | 1 = force 16-bit right-justified, normal polarity |
| pcm_left_o | output | 18 | Left sample, sign-extended |
| pcm_right_o | output | 18 | Right sample, sign-extended |
| pcm_valid_o | output | 1 | One-cycle pulse per completed stereo pair |

## Verification
The bench builds the bit stream for half-frames that are longer than the word, so that stray bits are present in both framings. A receiver that took the wrong end of the half-frame, or was off by one bit, would return shifted samples. Half-frames exactly as long as the word are also sent. In I2S framing this places the last bit of a word on the frame-clock transition itself, and a receiver that tagged that bit with the new channel would mismatch. The stimulus includes the most negative and most positive words of each length, which exposes a missing sign extension. Swapped polarity, strap override against contrary configuration inputs, and a frame clock that never toggles are also covered. A wrong polarity shows up as exchanged channels, and a receiver that captured before the first transition would emit a stray frame.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
    localparam int unsigned WORD_MAX = 18;
    localparam int unsigned WORD_MIN = 16;
endpackage

// File: rtl/audio_rx_edge.sv
module audio_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_clk_i,
    output logic rise_o
);
    typedef struct packed {
        logic lvl;
    } edge_t;

    edge_t e_q, e_d;

    always_comb begin
        e_d     = e_q;
        e_d.lvl = bit_clk_i;
        rise_o  = bit_clk_i & ~e_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end
endmodule

// File: rtl/audio_rx_slot.sv
module audio_rx_slot #(
    parameter int unsigned MAX_W = audio_rx_pkg::WORD_MAX,
    parameter int unsigned MIN_W = audio_rx_pkg::WORD_MIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             frame_i,
    input  logic             data_i,
    input  logic             i2s_i,
    input  logic             long_i,
    input  logic             swap_i,
    output logic             cap_o,
    output logic             cap_left_o,
    output logic [MAX_W-1:0] cap_word_o
);
    localparam int unsigned POS_W = $clog2(MAX_W) + 1;
    localparam logic [POS_W-1:0] POS_SAT = '1;
    localparam int unsigned EXT_W = MAX_W - MIN_W;

    typedef struct packed {
        logic [MAX_W-1:0] sr;
        logic [POS_W-1:0] pos;
        logic             frame;
        logic             seen;
    } slot_t;

    slot_t s_q, s_d;
    logic             flip_w;
    logic [POS_W-1:0] len_w;
    logic [MAX_W-1:0] raw_w;
    logic [MAX_W-1:0] shifted_w;

    always_comb begin
        s_d       = s_q;
        cap_o     = 1'b0;
        len_w     = long_i ? POS_W'(MAX_W) : POS_W'(MIN_W);
        flip_w    = rise_i && (frame_i != s_q.frame);
        shifted_w = {s_q.sr[MAX_W-2:0], data_i};
        raw_w     = s_q.sr;
        if (rise_i) begin
            s_d.frame = frame_i;
            s_d.seen  = s_q.seen | flip_w;
            if (flip_w)                s_d.pos = '0;
            else if (s_q.pos != POS_SAT) s_d.pos = s_q.pos + 1'b1;
            if (i2s_i) begin
                if (s_q.pos < len_w) s_d.sr = shifted_w;
                if (s_q.pos == len_w - 1'b1) begin
                    cap_o = 1'b1;
                    raw_w = shifted_w;
                end
            end else begin
                s_d.sr = shifted_w;
                cap_o  = flip_w && s_q.seen;
            end
        end
        cap_left_o = s_q.frame ^ swap_i;
        cap_word_o = long_i ? raw_w
                            : {{EXT_W{raw_w[MIN_W-1]}}, raw_w[MIN_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.pos <= POS_SAT;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/audio_rx_pair.sv
module audio_rx_pair #(
    parameter int unsigned MAX_W = audio_rx_pkg::WORD_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic             cap_left_i,
    input  logic [MAX_W-1:0] cap_word_i,
    output logic [MAX_W-1:0] left_o,
    output logic [MAX_W-1:0] right_o,
    output logic             valid_o
);
    typedef struct packed {
        logic [MAX_W-1:0] hold;
        logic             have_left;
        logic [MAX_W-1:0] left;
        logic [MAX_W-1:0] right;
        logic             valid;
    } pair_t;

    pair_t p_q, p_d;

    always_comb begin
        p_d       = p_q;
        p_d.valid = 1'b0;
        if (cap_i) begin
            if (cap_left_i) begin
                p_d.hold      = cap_word_i;
                p_d.have_left = 1'b1;
            end else if (p_q.have_left) begin
                p_d.left      = p_q.hold;
                p_d.right     = cap_word_i;
                p_d.valid     = 1'b1;
                p_d.have_left = 1'b0;
            end
        end
        left_o  = p_q.left;
        right_o = p_q.right;
        valid_o = p_q.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
    parameter int unsigned MAX_W = audio_rx_pkg::WORD_MAX,
    parameter int unsigned MIN_W = audio_rx_pkg::WORD_MIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_clk_i,
    input  logic             frame_clk_i,
    input  logic             ser_data_i,
    input  logic             fmt_i2s_i,
    input  logic             len_long_i,
    input  logic             lr_swap_i,
    input  logic             strap_mode_i,
    output logic [MAX_W-1:0] pcm_left_o,
    output logic [MAX_W-1:0] pcm_right_o,
    output logic             pcm_valid_o
);
    logic             rise_w;
    logic             cap_w;
    logic             cap_left_w;
    logic [MAX_W-1:0] cap_word_w;
    logic             eff_i2s_w;
    logic             eff_long_w;
    logic             eff_swap_w;

    always_comb begin
        eff_i2s_w  = fmt_i2s_i  & ~strap_mode_i;
        eff_long_w = len_long_i & ~strap_mode_i;
        eff_swap_w = lr_swap_i  & ~strap_mode_i;
    end

    audio_rx_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_clk_i (bit_clk_i),
        .rise_o    (rise_w)
    );

    audio_rx_slot #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise_w),
        .frame_i    (frame_clk_i),
        .data_i     (ser_data_i),
        .i2s_i      (eff_i2s_w),
        .long_i     (eff_long_w),
        .swap_i     (eff_swap_w),
        .cap_o      (cap_w),
        .cap_left_o (cap_left_w),
        .cap_word_o (cap_word_w)
    );

    audio_rx_pair #(.MAX_W(MAX_W)) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (cap_w),
        .cap_left_i (cap_left_w),
        .cap_word_i (cap_word_w),
        .left_o     (pcm_left_o),
        .right_o    (pcm_right_o),
        .valid_o    (pcm_valid_o)
    );
endmodule

// File: rtl/audio_rx_chk.sv
module audio_rx_chk #(
    parameter int unsigned MAX_W = audio_rx_pkg::WORD_MAX,
    parameter int unsigned MIN_W = audio_rx_pkg::WORD_MIN
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_clk_i,
    input logic             len_long_i,
    input logic             strap_mode_i,
    input logic [MAX_W-1:0] pcm_left_o,
    input logic [MAX_W-1:0] pcm_right_o,
    input logic             pcm_valid_o
);
    // R1: outputs cleared while reset is held
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (!pcm_valid_o && pcm_left_o == '0 && pcm_right_o == '0));

    // R6: valid is a single-cycle pulse
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid_o |=> !pcm_valid_o);

    // R6: output words change only together with valid
    p_words_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_left_o != $past(pcm_left_o) || pcm_right_o != $past(pcm_right_o))
        |-> pcm_valid_o);

    // R8: a frame is only reported right after a bit-clock rise was seen
    p_valid_after_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid_o |-> $past(bit_clk_i));

    // R4: short words arrive sign-extended
    p_sign_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_valid_o && ($past(strap_mode_i) || !$past(len_long_i)))
        |-> (pcm_right_o[MAX_W-1:MIN_W] == {(MAX_W-MIN_W){pcm_right_o[MIN_W-1]}}));
endmodule

bind audio_serial_rx audio_rx_chk #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_clk_i    (bit_clk_i),
    .len_long_i   (len_long_i),
    .strap_mode_i (strap_mode_i),
    .pcm_left_o   (pcm_left_o),
    .pcm_right_o  (pcm_right_o),
    .pcm_valid_o  (pcm_valid_o)
);

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        bclk = 1'b0;
    logic        fclk = 1'b0;
    logic        sdat = 1'b0;
    logic        cfg_i2s = 1'b0;
    logic        cfg_long = 1'b0;
    logic        cfg_swap = 1'b0;
    logic        cfg_strap = 1'b0;
    logic [17:0] left_w;
    logic [17:0] right_w;
    logic        valid_w;

    int checks = 0;
    int fails = 0;
    int got = 0;
    int n_exp = 0;
    string run_tag = "R1";
    logic [17:0] exp_l [0:15];
    logic [17:0] exp_r [0:15];
    logic [17:0] hw [0:31];

    always #2 clk = ~clk;

    audio_serial_rx u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_clk_i    (bclk),
        .frame_clk_i  (fclk),
        .ser_data_i   (sdat),
        .fmt_i2s_i    (cfg_i2s),
        .len_long_i   (cfg_long),
        .lr_swap_i    (cfg_swap),
        .strap_mode_i (cfg_strap),
        .pcm_left_o   (left_w),
        .pcm_right_o  (right_w),
        .pcm_valid_o  (valid_w)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [17:0] sext(input logic [17:0] v, input int n);
        return (n == 18) ? v : {{2{v[15]}}, v[15:0]};
    endfunction

    always @(negedge clk) begin
        if (rst_n && valid_w) begin
            if (got < n_exp) begin
                check(left_w == exp_l[got], {run_tag, " left word"}, left_w, exp_l[got]);
                check(right_w == exp_r[got], {run_tag, " right word"}, right_w, exp_r[got]);
            end else begin
                check(1'b0, {run_tag, " unexpected frame"}, got + 1, n_exp);
            end
            got++;
        end
    end

    task automatic tx(input bit lv, input bit d);
        @(negedge clk);
        fclk = lv;
        sdat = d;
        bclk = 1'b0;
        repeat (3) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        bclk = 1'b0;
        rst_n = 1'b0;
        got = 0;
        n_exp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input bit i2s, input bit lng, input bit swp, input bit strap,
                       input int slot, input int halves, input bit extremes,
                       input string tag);
        bit ei2s, elong, eswap;
        int n;
        logic [17:0] mask;
        ei2s  = i2s & ~strap;
        elong = lng & ~strap;
        eswap = swp & ~strap;
        n = elong ? 18 : 16;
        mask = elong ? 18'h3ffff : 18'h0ffff;
        cfg_i2s = i2s; cfg_long = lng; cfg_swap = swp; cfg_strap = strap;
        do_reset();
        run_tag = tag;
        for (int h = 0; h < halves; h++) begin
            logic [17:0] w;
            w = 18'($urandom) & mask;
            if (extremes && h == 0) w = 18'(1 << (n - 1));
            if (extremes && h == 1) w = 18'((1 << (n - 1)) - 1);
            hw[h] = w;
            if (h % 2 == 0) exp_l[h / 2] = sext(w, n);
            else            exp_r[h / 2] = sext(w, n);
        end
        n_exp = halves / 2;
        for (int p = 0; p < 3; p++) tx(eswap, 1'($urandom));
        for (int g = 0; g < (halves + 1) * slot; g++) begin
            bit lv, d;
            int hh, kk;
            lv = ((g / slot) % 2 == 0) ? ~eswap : eswap;
            d = 1'($urandom);
            if (ei2s) begin
                if (g >= 1) begin
                    hh = (g - 1) / slot;
                    kk = (g - 1) % slot;
                    if (hh < halves && kk < n) d = hw[hh][n - 1 - kk];
                end
            end else begin
                hh = g / slot;
                kk = g % slot;
                if (hh < halves && kk >= slot - n) d = hw[hh][slot - 1 - kk];
            end
            tx(lv, d);
        end
        repeat (20) @(negedge clk);
        check(got == n_exp, {tag, " R6 frame count"}, got, n_exp);
        if (n_exp > 0)
            check(left_w == exp_l[n_exp - 1], {tag, " R6 words held"}, left_w, exp_l[n_exp - 1]);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        void'($urandom(32'd4417));
        repeat (3) @(negedge clk);
        check(valid_w == 1'b0, "R1 valid in reset", valid_w, 0);
        check(left_w == 18'd0 && right_w == 18'd0, "R1 words in reset", left_w, 0);
        rst_n = 1'b1;

        // R8: frame clock never toggles after its first level
        cfg_i2s = 0; cfg_long = 0; cfg_swap = 0; cfg_strap = 0;
        do_reset();
        run_tag = "R8";
        for (int g = 0; g < 40; g++) tx(1'b1, 1'($urandom));
        repeat (20) @(negedge clk);
        check(got == 0, "R8 no frame without transition", got, 0);

        run(0, 0, 0, 0, 16, 8, 1, "R2 rj16 tight");
        run(0, 1, 0, 0, 24, 8, 1, "R2 R4 rj18 padded");
        run(0, 0, 0, 0, 21, 6, 1, "R2 R4 rj16 padded");
        run(1, 0, 0, 0, 16, 8, 1, "R3 i2s16 tight");
        run(1, 1, 0, 0, 18, 8, 1, "R3 R4 i2s18 tight");
        run(1, 1, 0, 0, 32, 6, 0, "R3 i2s18 padded");
        run(0, 1, 1, 0, 20, 8, 0, "R5 rj18 swapped");
        run(1, 0, 1, 0, 19, 8, 1, "R5 i2s16 swapped");
        run(1, 1, 1, 1, 20, 8, 1, "R7 strap overrides");
        run(0, 1, 0, 1, 16, 6, 0, "R7 strap rj16");
        for (int r = 0; r < 12; r++) begin
            bit ri2s, rlong, rswap, rstrap;
            int sl;
            ri2s = 1'($urandom); rlong = 1'($urandom);
            rswap = 1'($urandom); rstrap = ($urandom % 5 == 0);
            sl = ((rlong && !rstrap) ? 18 : 16) + int'($urandom % 6);
            run(ri2s, rlong, rswap, rstrap, sl, 8, 0, "R2 R3 R5 random");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule